// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Controller

This block tracks whether each DRAM bank has a row latched in its sense amplifiers, and which row that is. It turns each incoming access (bank, row, column, read/write) into the short series of commands that access needs. When the addressed row is already latched, only a column command is issued. When a different row is latched, the block issues a precharge, then an activate, then the column command. When the bank holds no row, it issues an activate and then the column command. Each of these operations occupies the command path for a fixed number of controller cycles, set by a parameter.

A static mode input chooses between two policies. In the keep-open policy the row stays latched after the access, so a later access to the same row is cheap. In the auto-close policy the bank is precharged right after every column operation. Whenever the data direction of a column operation differs from the previous column operation, one empty cycle is placed before it for bus turnaround. Requests are served strictly one at a time, in arrival order. Two saturating counters tally row hits and row misses.

Top module: `rowbuf_ctrl`

## Requirements
- R1: After synchronous reset every bank holds no row, `busy` and `done` are low, `cmd_kind` is 0 (no command) and both counters read zero.
- R2: A request whose bank holds the requested row produces exactly one column command, and `done` rises OP_LAT cycles after the accepting edge (plus one turnaround cycle if R7 applies).
- R3: A request to a bank holding a different row produces, in this order, a precharge, an activate and a column command to that bank, each starting OP_LAT cycles after the previous one. `done` comes 3*OP_LAT cycles after acceptance (plus turnaround).
- R4: A request to a bank holding no row produces an activate and then a column command, with `done` 2*OP_LAT cycles after acceptance. Afterwards the bank holds the activated row.
- R5: In keep-open mode (`close_mode`=0) the row stays latched after the access, and `busy` falls in the cycle after `done`.
- R6: In auto-close mode (`close_mode`=1) a precharge to the same bank is issued in the cycle after `done`, and `busy` stays high for OP_LAT more cycles. The next access to that bank is then treated as a no-row access.
- R7: When the direction of a column command differs from the direction of the previous column command since reset, exactly one cycle with no command is inserted before it. This cycle is never inserted before the first column command after reset.
- R8: `cmd_kind` encodes 0 = none, 1 = precharge, 2 = activate, 3 = column. Each operation drives its code only in its first cycle, together with the request's bank on `cmd_bank`. Activates also carry the row on `cmd_row`, and column commands carry `cmd_col` and `cmd_write` (1 = write).
- R9: Each accepted request increments `hit_count` if it is a row hit and `miss_count` otherwise. Both counters saturate at all ones.
- R10: A request is accepted only on an edge where `req_valid` is high and `busy` is low. Any `req_valid` seen while `busy` is high changes neither the counters nor the commands.
- R11: `done` is a single-cycle pulse, high only during the last cycle of the column operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| close_mode | input | 1 | 1 = auto-close policy, 0 = keep-open; change only under reset |
| req_valid | input | 1 | Request present |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | Request in progress; new requests not accepted |
| done | output | 1 | Pulse in the last column-operation cycle |
| cmd_kind | output | 2 | Command code: 0 none, 1 precharge, 2 activate, 3 column |
| cmd_bank | output | $clog2(NUM_BANKS) | Bank of the issued command |
| cmd_row | output | ROW_W | Row of an activate |
| cmd_col | output | COL_W | Column of a column command |
| cmd_write | output | 1 | Direction of a column command |
| hit_count | output | CNT_W | Saturating row-hit tally |
| miss_count | output | CNT_W | Saturating row-miss tally |

## Verification
The bench targets the three access classes on a bank that was just touched and also on an untouched neighbour. A design that shared one row register across banks would report false hits, and one that cleared the row too late would hit after a precharge. It alternates read and write to catch a missing or doubled turnaround cycle, including the first column command after reset, which must get none. It holds `req_valid` high throughout a busy request with a different address, which would expose a controller that accepts or counts while busy. It drives the hit counter past its limit to catch wraparound, and it checks that auto-close reissues an activate on the next access rather than treating it as a hit.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_ACT  = 2'd2,
        CMD_COL  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ACT  = 3'd2,
        ST_TURN = 3'd3,
        ST_COL  = 3'd4,
        ST_APRE = 3'd5
    } seq_st_e;

    // Command code an operation state drives in its first cycle.
    function automatic cmd_e cmd_of_state(seq_st_e st);
        case (st)
            ST_PRE:  return CMD_PRE;
            ST_APRE: return CMD_PRE;
            ST_ACT:  return CMD_ACT;
            ST_COL:  return CMD_COL;
            default: return CMD_NONE;
        endcase
    endfunction

    // Entry state into the column phase, with turnaround if direction flips.
    function automatic seq_st_e col_entry(logic have_last, logic last_wr, logic wr);
        return (have_last && (last_wr != wr)) ? ST_TURN : ST_COL;
    endfunction

endpackage

// File: rtl/rbc_bank_table.sv
module rbc_bank_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 12,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_valid,
    output logic [ROW_W-1:0]  rd_row,
    input  logic              open_en,
    input  logic [BANK_W-1:0] open_bank,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              close_en,
    input  logic [BANK_W-1:0] close_bank
);

    logic [NUM_BANKS-1:0] valid_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < NUM_BANKS; i++) row_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (close_en && (close_bank == BANK_W'(i))) begin
                    valid_q[i] <= 1'b0;
                end else if (open_en && (open_bank == BANK_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    row_q[i]   <= open_row;
                end
            end
        end
    end

    assign rd_valid = valid_q[rd_bank];
    assign rd_row   = row_q[rd_bank];

    // R6 / R3: a precharge drops the latched row at once
    p_close_clears_r3: assert property (@(posedge clk) disable iff (rst)
        close_en |=> !valid_q[$past(close_bank)]);

    // R4: an activate leaves the bank holding the requested row
    p_open_latches_r4: assert property (@(posedge clk) disable iff (rst)
        (open_en && !close_en) |=> (valid_q[$past(open_bank)] && row_q[$past(open_bank)] == $past(open_row)));

endmodule

// File: rtl/rbc_sat_counter.sv
module rbc_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] value
);

    logic [W-1:0] v_q;

    always_ff @(posedge clk) begin
        if (rst)                   v_q <= '0;
        else if (inc && v_q != '1) v_q <= v_q + 1'b1;
    end

    assign value = v_q;

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && v_q == '1) |=> (v_q == '1));

    p_step_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && v_q != '1) |=> (v_q == $past(v_q) + 1'b1));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(v_q));

endmodule

// File: rtl/rbc_sequencer.sv
module rbc_sequencer
    import rbc_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int OP_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_mode,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              lk_valid,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              tbl_open,
    output logic              tbl_close,
    output logic [BANK_W-1:0] tbl_bank,
    output logic [ROW_W-1:0]  tbl_row,
    output logic              hit_inc,
    output logic              miss_inc,
    output logic              busy,
    output logic              done,
    output cmd_e              cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_write
);

    localparam int CW = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(OP_LAT - 1);

    seq_st_e           st_q, st_d;
    logic [CW-1:0]     cnt_q;
    logic [BANK_W-1:0] cur_bank_q;
    logic [ROW_W-1:0]  cur_row_q;
    logic [COL_W-1:0]  cur_col_q;
    logic              cur_wr_q;
    logic              have_last_q, last_wr_q;
    logic              accept, lk_hit, op_last;

    assign accept  = (st_q == ST_IDLE) && req_valid;
    assign lk_hit  = lk_valid && (lk_row == req_row);
    assign op_last = (cnt_q == LAST);

    always_comb begin
        st_d      = st_q;
        tbl_open  = 1'b0;
        tbl_close = 1'b0;
        tbl_bank  = cur_bank_q;
        tbl_row   = cur_row_q;
        hit_inc   = 1'b0;
        miss_inc  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tbl_bank = req_bank;
                    if (lk_hit) begin
                        hit_inc = 1'b1;
                        st_d    = col_entry(have_last_q, last_wr_q, req_write);
                    end else begin
                        miss_inc = 1'b1;
                        if (lk_valid) begin
                            tbl_close = 1'b1;
                            st_d      = ST_PRE;
                        end else begin
                            st_d = ST_ACT;
                        end
                    end
                end
            end
            ST_PRE:  if (op_last) st_d = ST_ACT;
            ST_ACT: begin
                if (op_last) begin
                    tbl_open = 1'b1;
                    st_d     = col_entry(have_last_q, last_wr_q, cur_wr_q);
                end
            end
            ST_TURN: st_d = ST_COL;
            ST_COL: begin
                if (op_last) begin
                    tbl_close = close_mode;
                    st_d      = close_mode ? ST_APRE : ST_IDLE;
                end
            end
            ST_APRE: if (op_last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            cur_bank_q  <= '0;
            cur_row_q   <= '0;
            cur_col_q   <= '0;
            cur_wr_q    <= 1'b0;
            have_last_q <= 1'b0;
            last_wr_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)     cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
            if (accept) begin
                cur_bank_q <= req_bank;
                cur_row_q  <= req_row;
                cur_col_q  <= req_col;
                cur_wr_q   <= req_write;
            end
            if (st_q == ST_COL && cnt_q == '0) begin
                have_last_q <= 1'b1;
                last_wr_q   <= cur_wr_q;
            end
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_COL) && op_last;
    assign cmd_kind  = (cnt_q == '0) ? cmd_of_state(st_q) : CMD_NONE;
    assign cmd_bank  = cur_bank_q;
    assign cmd_row   = cur_row_q;
    assign cmd_col   = cur_col_q;
    assign cmd_write = cur_wr_q;

    p_hit_to_col_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && lk_hit) |=> (st_q == ST_COL || st_q == ST_TURN));

    p_pre_to_act_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PRE && op_last) |=> (cmd_kind == CMD_ACT));

    p_empty_bank_act_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && !lk_valid) |=> (cmd_kind == CMD_ACT));

    p_open_release_r5: assert property (@(posedge clk) disable iff (rst)
        (!close_mode && done) |=> !busy);

    p_auto_pre_r6: assert property (@(posedge clk) disable iff (rst)
        (close_mode && done) |=> (cmd_kind == CMD_PRE && busy));

    p_turn_single_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TURN) |=> (cmd_kind == CMD_COL));

    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(hit_inc || miss_inc));

endmodule

// File: rtl/rowbuf_ctrl.sv
module rowbuf_ctrl
    import rbc_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int OP_LAT    = 3,
    parameter int CNT_W     = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              close_mode,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    output logic              busy,
    output logic              done,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_write,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int NUM_CNT = 2;

    logic              lk_valid;
    logic [ROW_W-1:0]  lk_row;
    logic              tbl_open, tbl_close;
    logic [BANK_W-1:0] tbl_bank;
    logic [ROW_W-1:0]  tbl_row;
    logic              hit_inc, miss_inc;
    cmd_e              kind;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0]  cnt_vals [NUM_CNT];

    rbc_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .rd_bank    (req_bank),
        .rd_valid   (lk_valid),
        .rd_row     (lk_row),
        .open_en    (tbl_open),
        .open_bank  (tbl_bank),
        .open_row   (tbl_row),
        .close_en   (tbl_close),
        .close_bank (tbl_bank)
    );

    rbc_sequencer #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .OP_LAT(OP_LAT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .close_mode (close_mode),
        .req_valid  (req_valid),
        .req_bank   (req_bank),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_write  (req_write),
        .lk_valid   (lk_valid),
        .lk_row     (lk_row),
        .tbl_open   (tbl_open),
        .tbl_close  (tbl_close),
        .tbl_bank   (tbl_bank),
        .tbl_row    (tbl_row),
        .hit_inc    (hit_inc),
        .miss_inc   (miss_inc),
        .busy       (busy),
        .done       (done),
        .cmd_kind   (kind),
        .cmd_bank   (cmd_bank),
        .cmd_row    (cmd_row),
        .cmd_col    (cmd_col),
        .cmd_write  (cmd_write)
    );

    assign cmd_kind = kind;
    assign inc_vec  = {miss_inc, hit_inc};

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        rbc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc_vec[gi]),
            .value (cnt_vals[gi])
        );
    end

    assign hit_count  = cnt_vals[0];
    assign miss_count = cnt_vals[1];

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_cmd_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (kind != CMD_NONE) |-> busy);

endmodule

// File: tb/rowbuf_ctrl_tb_top.sv
module rowbuf_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 8;
    localparam int BW   = 3;
    localparam int RW   = 12;
    localparam int CLW  = 8;
    localparam int LAT  = 3;
    localparam int NW   = 8;
    localparam int CMAX = (1 << NW) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           close_mode = 1'b0;
    logic           req_valid = 1'b0;
    logic [BW-1:0]  req_bank = '0;
    logic [RW-1:0]  req_row = '0;
    logic [CLW-1:0] req_col = '0;
    logic           req_write = 1'b0;
    logic           busy, done, cmd_write;
    logic [1:0]     cmd_kind;
    logic [BW-1:0]  cmd_bank;
    logic [RW-1:0]  cmd_row;
    logic [CLW-1:0] cmd_col;
    logic [NW-1:0]  hit_count, miss_count;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rowbuf_ctrl #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CLW), .OP_LAT(LAT), .CNT_W(NW)) dut_i (
        .clk(clk), .rst(rst), .close_mode(close_mode),
        .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_write(req_write),
        .busy(busy), .done(done), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_write(cmd_write),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    bit             m_valid [NB];
    logic [RW-1:0]  m_row   [NB];
    bit             m_have;
    bit             m_lastwr;
    int             m_hits, m_miss;

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(bit cmode);
        req_valid  = 1'b0;
        rst        = 1'b1;
        close_mode = cmode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NB; i++) begin
            m_valid[i] = 1'b0;
            m_row[i]   = '0;
        end
        m_have = 1'b0; m_lastwr = 1'b0; m_hits = 0; m_miss = 0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 cmd_kind after reset", int'(cmd_kind), 0);
        chk("R1 hit_count after reset", int'(hit_count), 0);
        chk("R1 miss_count after reset", int'(miss_count), 0);
    endtask

    task automatic run_req(int b, int r, int c, bit w, bit junk);
        bit  hit, turn;
        int  n_ops, pos, done_exp, busy_exp;
        int  exp_kind [4];
        int  exp_k    [4];
        int  got_kind [8];
        int  got_k    [8];
        int  n_got, done_k, n_done, busy_k, bad_fields;

        hit  = m_valid[b] && (m_row[b] == RW'(r));
        turn = m_have && (m_lastwr != w);
        n_ops = 0;
        if (!hit && m_valid[b]) begin exp_kind[n_ops] = 1; n_ops++; end
        if (!hit)               begin exp_kind[n_ops] = 2; n_ops++; end
        exp_kind[n_ops] = 3; n_ops++;
        pos = 1;
        for (int i = 0; i < n_ops; i++) begin
            if (exp_kind[i] == 3 && turn) pos++;
            exp_k[i] = pos;
            pos += LAT;
        end
        done_exp = pos - 1;
        if (close_mode) begin
            exp_kind[n_ops] = 1; exp_k[n_ops] = pos; n_ops++;
            busy_exp = pos + LAT;
        end else begin
            busy_exp = pos;
        end

        // model update
        if (hit) begin if (m_hits < CMAX) m_hits++; end
        else     begin if (m_miss < CMAX) m_miss++; end
        m_valid[b] = !close_mode;
        m_row[b]   = RW'(r);
        m_have     = 1'b1;
        m_lastwr   = w;

        while (busy) @(negedge clk);
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_row   = RW'(r);
        req_col   = CLW'(c);
        req_write = w;

        n_got = 0; done_k = -1; n_done = 0; busy_k = -1; bad_fields = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (junk) begin
                    req_bank = BW'((b + 1) % NB);
                    req_row  = RW'(r + 1);
                    req_col  = CLW'(c + 1);
                    req_write = ~w;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (cmd_kind != 2'd0) begin
                if (n_got < 8) begin
                    got_kind[n_got] = int'(cmd_kind);
                    got_k[n_got]    = k;
                end
                n_got++;
                if (cmd_bank != BW'(b)) bad_fields++;
                if (cmd_kind == 2'd2 && cmd_row != RW'(r)) bad_fields++;
                if (cmd_kind == 2'd3 && (cmd_col != CLW'(c) || cmd_write != w)) bad_fields++;
            end
            if (done) begin
                n_done++;
                if (done_k < 0) done_k = k;
                req_valid = 1'b0;
            end
            if (!busy) begin
                busy_k = k;
                break;
            end
        end
        req_valid = 1'b0;

        if (hit)            chk("R2 hit done cycle", done_k, done_exp);
        else if (n_ops > 2 + int'(close_mode)) chk("R3 miss done cycle", done_k, done_exp);
        else                chk("R4 empty-bank done cycle", done_k, done_exp);
        chk("R11 done pulse count", n_done, 1);
        if (close_mode) chk("R6 busy release cycle", busy_k, busy_exp);
        else            chk("R5 busy release cycle", busy_k, busy_exp);
        chk("R8 command count", n_got, n_ops);
        for (int i = 0; i < n_ops && i < n_got && i < 8; i++) begin
            chk("R8 command kind in order", got_kind[i], exp_kind[i]);
            if (turn && exp_kind[i] == 3) chk("R7 column slot after turnaround", got_k[i], exp_k[i]);
            else                          chk("R3 command slot", got_k[i], exp_k[i]);
        end
        chk("R8 command fields", bad_fields, 0);
        if (junk) begin
            chk("R10 hit_count with busy request", int'(hit_count), m_hits);
            chk("R10 miss_count with busy request", int'(miss_count), m_miss);
        end else begin
            chk("R9 hit_count", int'(hit_count), m_hits);
            chk("R9 miss_count", int'(miss_count), m_miss);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2718));

        // keep-open policy
        do_reset(1'b0);
        run_req(1, 5, 10, 1'b0, 1'b0);   // R4 empty bank, first column: no turnaround (R7)
        run_req(1, 5, 11, 1'b0, 1'b0);   // R2 hit, R5 row kept open
        run_req(1, 6, 12, 1'b0, 1'b0);   // R3 miss on active bank
        run_req(1, 6, 13, 1'b1, 1'b0);   // R7 hit with direction switch
        run_req(2, 6, 14, 1'b1, 1'b0);   // R4 other bank holds no row
        run_req(1, 6, 15, 1'b1, 1'b0);   // R2 bank 1 still open
        run_req(1, 6, 16, 1'b0, 1'b1);   // R10 request held during busy
        run_req(2, 7, 17, 1'b0, 1'b1);   // R10 during a miss
        for (int i = 0; i < 150; i++) begin
            run_req(int'($urandom % 4), int'($urandom % 3), int'($urandom % 256),
                    1'($urandom % 2), ($urandom % 8) == 0);
        end
        // R9 saturation of the hit counter
        for (int i = 0; i < 270; i++) run_req(0, 0, i % 256, 1'b0, 1'b0);
        chk("R9 hit_count saturated", int'(hit_count), CMAX);

        // auto-close policy
        do_reset(1'b1);
        run_req(3, 1, 20, 1'b0, 1'b0);   // R6 activate, column, auto precharge
        run_req(3, 1, 21, 1'b0, 1'b0);   // R6 same row is not a hit after auto-close
        run_req(3, 1, 22, 1'b1, 1'b0);   // R7 turnaround in auto-close mode
        for (int i = 0; i < 100; i++) begin
            run_req(int'($urandom % 4), int'($urandom % 3), int'($urandom % 256),
                    1'($urandom % 2), ($urandom % 8) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule